// File: doc/BRIEF.md
# Debug Mode Switching State Machine

This block is the control sequencer of an in-circuit emulator placed beside a bond-out microcontroller. While the CPU runs user code from its internal flash, the sequencer watches the instruction fetch strobe and fetch address together with a breakpoint flag from a separate breakpoint unit. When a break event occurs, the sequencer steers the CPU into a monitor program held in external memory. It does this by feeding a three-byte long-jump instruction straight into the fetch stream. Opcode 0x02 comes first, then the high byte of the monitor entry address, then the low byte.

While the monitor runs, the sequencer keeps the program-space select, the interrupt mask and the peripheral clock-stop asserted. When the host has issued a run command, the monitor executes its final jump instruction, which sits at a fixed exit address. The sequencer then supplies the saved user address as that jump's operand bytes, drops all three controls and hands the CPU back to flash at the interrupted instruction.

The state is held in a small two-process state machine. Byte injection is a separate multiplexer driven by a byte counter. Every address width, the opcode value and the monitor addresses are parameters.

Top module: `dbgsw_top`

## Requirements
- R1: After reset the machine is in user mode: `ext_space`, `irq_mask`, `periph_clk_stop` and `inj_en` are all 0.
- R2: In user mode, a cycle with both `fetch_stb` and `brk_hit` high is a break event. In the next cycle `ext_space`, `irq_mask` and `periph_clk_stop` are 1, `inj_en` is 1 and `inj_byte` is 0x02. A `brk_hit` without `fetch_stb` has no effect.
- R3: During jump insertion, successive fetch strobes receive 0x02, then MON_ENTRY[15:8], then MON_ENTRY[7:0] on `inj_byte`, with `inj_en` high. Cycles without `fetch_stb` leave the presented byte unchanged.
- R4: In the cycle after the third injected fetch, the machine is in monitor mode. `inj_en` is 0, and `ext_space`, `irq_mask` and `periph_clk_stop` remain 1.
- R5: In monitor mode, a fetch at EXIT_ADDR leaves monitor mode only if `host_run` was high in some monitor-mode cycle up to and including that fetch cycle. Otherwise the machine stays in monitor mode.
- R6: After the qualifying exit fetch, the next two fetch strobes receive the saved resume address, high byte first, with `inj_en` high. The three controls stay at 1 during these cycles.
- R7: In the cycle after the second return byte is fetched, `ext_space`, `irq_mask`, `periph_clk_stop` and `inj_en` are all 0. A break event is accepted from that cycle on.
- R8: The resume address is the `fetch_addr` of the break event's fetch cycle.
- R9: `brk_hit` is ignored outside user mode. It changes neither the injected byte sequence, the mode, nor the saved resume address.
- R10: `host_run` is ignored outside monitor mode. A run pulse given in user mode or during jump insertion does not arm the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_stb | input | 1 | CPU instruction/operand fetch strobe |
| fetch_addr | input | AW (16) | CPU fetch address |
| brk_hit | input | 1 | Breakpoint flag for the current fetch |
| host_run | input | 1 | Host run command pulse |
| inj_en | output | 1 | Injected byte replaces the fetch data |
| inj_byte | output | 8 | Byte presented on the fetch data bus |
| ext_space | output | 1 | Program-space select: 1 = external monitor memory |
| irq_mask | output | 1 | Masks all external interrupts |
| periph_clk_stop | output | 1 | Stops the peripheral clock |

## Verification
Two pairs of functions can land in one cycle. The first is the host run command and the monitor's exit fetch. The bench sometimes pulses `host_run` on the exit fetch itself and sometimes some cycles earlier, and in both cases it expects the return bytes at once. It also sometimes fetches the exit address with no run pending and expects the machine to stay in monitor mode. The second pair is a return completing and a new break starting. The bench asserts `brk_hit` on the very first user fetch after the last return byte and expects a fresh jump sequence. Random `brk_hit` noise throughout the debug phases is judged through the resume bytes that later come out.

// File: rtl/dbgsw_pkg.sv
package dbgsw_pkg;

    typedef enum logic [1:0] {
        MODE_USER = 2'd0,
        MODE_JUMP = 2'd1,
        MODE_MON  = 2'd2,
        MODE_RET  = 2'd3
    } mode_e;

endpackage

// File: rtl/dbgsw_inject.sv
module dbgsw_inject #(
    parameter int          AW       = 16,
    parameter logic [7:0]  JMP_OP   = 8'h02,
    parameter int          NB       = AW / 8,
    parameter int          CW       = $clog2(NB + 1)
) (
    input  logic          active,
    input  logic          use_resume,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] entry_addr,
    input  logic [AW-1:0] resume_addr,
    output logic          inj_en,
    output logic [7:0]    inj_byte
);

    logic [AW-1:0] tgt;
    logic [7:0]    abyte [NB];

    assign tgt = use_resume ? resume_addr : entry_addr;

    // byte 0 is the most significant address byte, sent first
    for (genvar g = 0; g < NB; g++) begin : g_slice
        assign abyte[g] = tgt[AW-1-8*g -: 8];
    end

    always_comb begin
        inj_byte = JMP_OP;
        for (int i = 0; i < NB; i++) begin
            if (cnt == CW'(i + 1)) inj_byte = abyte[i];
        end
        if (!active) inj_byte = 8'h00;
    end

    assign inj_en = active;

endmodule

// File: rtl/dbgsw_fsm.sv
module dbgsw_fsm
    import dbgsw_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [AW-1:0] EXIT_ADDR = 16'hFFF0,
    parameter int          NB        = AW / 8,
    parameter int          CW        = $clog2(NB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_stb,
    input  logic [AW-1:0] fetch_addr,
    input  logic          brk_hit,
    input  logic          host_run,
    output mode_e         mode,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] resume
);

    localparam logic [CW-1:0] LAST = CW'(NB);

    typedef struct packed {
        mode_e         mode;
        logic [CW-1:0] cnt;
        logic          armed;
        logic [AW-1:0] resume;
    } ctl_s;

    ctl_s q, d;

    always_comb begin
        d = q;
        unique case (q.mode)
            MODE_USER: begin
                if (fetch_stb && brk_hit) begin
                    d.mode   = MODE_JUMP;
                    d.cnt    = '0;
                    d.armed  = 1'b0;
                    d.resume = fetch_addr;
                end
            end
            MODE_JUMP: begin
                if (fetch_stb) begin
                    if (q.cnt == LAST) begin
                        d.mode = MODE_MON;
                        d.cnt  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            MODE_MON: begin
                if (host_run) d.armed = 1'b1;
                if (fetch_stb && fetch_addr == EXIT_ADDR && (q.armed || host_run)) begin
                    d.mode  = MODE_RET;
                    d.cnt   = CW'(1);
                    d.armed = 1'b0;
                end
            end
            MODE_RET: begin
                if (fetch_stb) begin
                    if (q.cnt == LAST) begin
                        d.mode = MODE_USER;
                        d.cnt  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.mode = MODE_USER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: MODE_USER, cnt: '0, armed: 1'b0, resume: '0};
        end else begin
            q <= d;
        end
    end

    assign mode   = q.mode;
    assign cnt    = q.cnt;
    assign resume = q.resume;

    a_r1_reset_user: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> q.mode == MODE_USER);

    a_r2_break_enters_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_USER && fetch_stb && brk_hit) |=> (q.mode == MODE_JUMP && q.cnt == '0));

    a_r8_resume_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_USER && fetch_stb && brk_hit) |=> q.resume == $past(fetch_addr));

    a_r4_jump_to_monitor: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_JUMP && fetch_stb && q.cnt == LAST) |=> q.mode == MODE_MON);

    a_r5_no_exit_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_MON && !q.armed && !host_run) |=> q.mode == MODE_MON);

    a_r7_return_to_user: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_RET && fetch_stb && q.cnt == LAST) |=> q.mode == MODE_USER);

    a_r9_resume_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode != MODE_USER) |=> $stable(q.resume));

    a_r10_no_arm_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode != MODE_MON) |=> !q.armed);

endmodule

// File: rtl/dbgsw_top.sv
module dbgsw_top
    import dbgsw_pkg::*;
#(
    parameter int            AW        = 16,
    parameter logic [7:0]    JMP_OP    = 8'h02,
    parameter logic [AW-1:0] MON_ENTRY = 16'hF800,
    parameter logic [AW-1:0] EXIT_ADDR = 16'hFFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_stb,
    input  logic [AW-1:0] fetch_addr,
    input  logic          brk_hit,
    input  logic          host_run,
    output logic          inj_en,
    output logic [7:0]    inj_byte,
    output logic          ext_space,
    output logic          irq_mask,
    output logic          periph_clk_stop
);

    localparam int NB = AW / 8;
    localparam int CW = $clog2(NB + 1);

    mode_e         mode;
    logic [CW-1:0] cnt;
    logic [AW-1:0] resume;
    logic          debug_on;

    dbgsw_fsm #(.AW(AW), .EXIT_ADDR(EXIT_ADDR), .NB(NB), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_stb  (fetch_stb),
        .fetch_addr (fetch_addr),
        .brk_hit    (brk_hit),
        .host_run   (host_run),
        .mode       (mode),
        .cnt        (cnt),
        .resume     (resume)
    );

    dbgsw_inject #(.AW(AW), .JMP_OP(JMP_OP), .NB(NB), .CW(CW)) u_inj (
        .active      (mode == MODE_JUMP || mode == MODE_RET),
        .use_resume  (mode == MODE_RET),
        .cnt         (cnt),
        .entry_addr  (MON_ENTRY),
        .resume_addr (resume),
        .inj_en      (inj_en),
        .inj_byte    (inj_byte)
    );

    assign debug_on        = (mode != MODE_USER);
    assign ext_space       = debug_on;
    assign irq_mask        = debug_on;
    assign periph_clk_stop = debug_on;

    a_r4_monitor_no_inject: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MON) |-> (!inj_en && ext_space && irq_mask && periph_clk_stop));

    a_r3_jump_opcode_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mode == MODE_JUMP)) |-> (inj_en && inj_byte == JMP_OP));

    a_r7_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_USER) |-> (!inj_en && !ext_space && !irq_mask && !periph_clk_stop));

endmodule

// File: tb/sim_dbgsw_top.sv
module sim_dbgsw_top;

    localparam logic [15:0] ENTRY = 16'hF800;
    localparam logic [15:0] EXITA = 16'hFFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_stb = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        brk_hit = 1'b0;
    logic        host_run = 1'b0;
    logic        inj_en;
    logic [7:0]  inj_byte;
    logic        ext_space, irq_mask, periph_clk_stop;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbgsw_top #(.AW(16), .JMP_OP(8'h02), .MON_ENTRY(ENTRY), .EXIT_ADDR(EXITA)) u0 (
        .clk, .rst_n, .fetch_stb, .fetch_addr, .brk_hit, .host_run,
        .inj_en, .inj_byte, .ext_space, .irq_mask, .periph_clk_stop
    );

    function automatic logic [3:0] ctl_word(input logic c, input logic e);
        return {c, c, c, e};
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ctl(input logic c, input logic e, input string tag);
        chk({12'd0, ext_space, irq_mask, periph_clk_stop, inj_en}, {12'd0, ctl_word(c, e)}, tag);
    endtask

    // one clock step: inputs applied at negedge, held through posedge
    task automatic step(input logic fs, input logic [15:0] a, input logic b, input logic r);
        fetch_stb  = fs;
        fetch_addr = a;
        brk_hit    = b;
        host_run   = r;
        @(negedge clk);
        fetch_stb = 1'b0;
        brk_hit   = 1'b0;
        host_run  = 1'b0;
    endtask

    function automatic logic [15:0] mon_addr();
        logic [15:0] a;
        a = 16'hF800 + 16'($urandom % 16'h07F0);
        return a;
    endfunction

    // full debug excursion; returns nothing, checks inline
    task automatic episode(input logic [15:0] baddr, input int run_mode, input bit noise,
                           input bit brk_idle_first);
        // a few user fetches
        for (int i = 0; i < 1 + int'($urandom % 3); i++) begin
            step(1'b1, 16'($urandom % 16'h8000), 1'b0, 1'b0);
            chk_ctl(1'b0, 1'b0, "R7 user mode quiet");
        end
        if (brk_idle_first) begin
            step(1'b0, baddr ^ 16'h0101, 1'b1, 1'b0);
            chk_ctl(1'b0, 1'b0, "R2 brk without fetch ignored");
        end
        // R10: run pulse while in user mode must not arm
        step(1'b0, 16'h0, 1'b0, 1'b1);
        // break event
        step(1'b1, baddr, 1'b1, 1'b0);
        chk_ctl(1'b1, 1'b1, "R2 break asserts controls");
        chk({8'd0, inj_byte}, 16'h0002, "R2 opcode presented");
        // jump bytes with stalls and noise
        for (int k = 0; k < 3; k++) begin
            logic [7:0] e;
            e = (k == 0) ? 8'h02 : (k == 1) ? ENTRY[15:8] : ENTRY[7:0];
            for (int s = 0; s < int'($urandom % 3); s++) begin
                step(1'b0, 16'h1234, noise & 1'($urandom), 1'b1);
                chk({8'd0, inj_byte}, {8'd0, e}, "R3 byte held during stall");
            end
            chk({7'd0, inj_en, inj_byte}, {7'd0, 1'b1, e}, "R3 jump byte");
            step(1'b1, 16'h1000 + 16'(k), noise & 1'($urandom), 1'b0);
        end
        chk_ctl(1'b1, 1'b0, "R4 monitor mode");
        // monitor code
        for (int i = 0; i < 2 + int'($urandom % 4); i++) begin
            step(1'b1, mon_addr(), noise & 1'($urandom), 1'b0);
            chk_ctl(1'b1, 1'b0, "R4 monitor stays");
        end
        // exit fetch with no run issued in monitor (R10 pulses earlier must not count)
        step(1'b1, EXITA, noise & 1'($urandom), 1'b0);
        chk_ctl(1'b1, 1'b0, "R5 exit fetch without run stays in monitor");
        chk_ctl(1'b1, 1'b0, "R10 earlier run pulse not armed");
        if (run_mode == 0) begin
            step(1'b0, 16'h0, 1'b0, 1'b1);
            step(1'b1, mon_addr(), 1'b0, 1'b0);
            chk_ctl(1'b1, 1'b0, "R5 armed but not at exit");
            step(1'b1, EXITA, noise & 1'($urandom), 1'b0);
        end else begin
            step(1'b1, EXITA, noise & 1'($urandom), 1'b1); // run same cycle as exit
        end
        chk_ctl(1'b1, 1'b1, "R5 exit after run");
        for (int k = 0; k < 2; k++) begin
            logic [7:0] e;
            e = (k == 0) ? baddr[15:8] : baddr[7:0];
            for (int s = 0; s < int'($urandom % 2); s++) begin
                step(1'b0, 16'h0, noise & 1'($urandom), 1'b0);
                chk({8'd0, inj_byte}, {8'd0, e}, "R6 return byte held");
            end
            chk({7'd0, inj_en, inj_byte}, {7'd0, 1'b1, e}, "R8 R9 return byte = break address");
            chk_ctl(1'b1, 1'b1, "R6 controls held in return");
            step(1'b1, EXITA + 16'(k + 1), noise & 1'($urandom), 1'b0);
        end
        chk_ctl(1'b0, 1'b0, "R7 back in user mode");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_ctl(1'b0, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_ctl(1'b0, 1'b0, "R1 after reset");
        episode(16'h1234, 0, 1'b0, 1'b1);
        episode(16'hABCD, 1, 1'b1, 1'b0);
        // corner: break on the very first user fetch after return
        step(1'b1, 16'h0420, 1'b1, 1'b0);
        chk_ctl(1'b1, 1'b1, "R7 immediate rebreak accepted");
        for (int k = 0; k < 3; k++) step(1'b1, 16'h0, 1'b0, 1'b0);
        step(1'b1, EXITA, 1'b0, 1'b1);
        chk({8'd0, inj_byte}, 16'h0004, "R8 rebreak resume high");
        step(1'b1, 16'h0, 1'b0, 1'b0);
        chk({8'd0, inj_byte}, 16'h0020, "R8 rebreak resume low");
        step(1'b1, 16'h0, 1'b0, 1'b0);
        for (int n = 0; n < 40; n++) begin
            episode(16'($urandom), int'($urandom % 2), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule